// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between one core's load/store port and a memory or cache port. A store is written into a small local queue and retires in the cycle it is offered, so the core never waits for a slow memory write. The queued stores are written to memory oldest first, one at a time, whenever the memory port signals that it can take a write.

A load first searches the queue. If one or more queued stores match its address, it returns the data of the newest match without touching memory. If nothing matches, it goes to memory at once, ahead of any older queued stores to other addresses. This allows a load to pass an earlier store, the one reordering that total store ordering permits. A fence stalls the core until the queue has emptied. While a fence is held and the queue is not empty, no load is accepted.

Top module: `tso_store_buffer`

## Requirements
- R1: `st_ready` is high whenever fewer than DEPTH stores are queued, so a store is accepted in the cycle it is offered. When DEPTH stores are queued, `st_ready` is low and the core stalls.
- R2: Queued stores are offered to memory as writes (`mem_req_write`=1) in the order they were accepted. The oldest entry's address and data are held until `mem_req_ready` takes them.
- R3: A load whose address matches queued stores is accepted without any memory request. In the cycle after acceptance, `ld_rsp_valid` is 1 and `ld_rsp_data` carries the data of the youngest matching store.
- R4: A load with no matching queued store is sent to memory as a read (`mem_req_write`=0) even while older stores to other addresses wait. Its response is the memory read data.
- R5: When a load miss and a queued write compete for the memory port in the same cycle, the port carries the load.
- R6: `fence_ready` is high exactly when the queue is empty. While `fence_valid` is high and the queue is not empty, `ld_ready` stays low.
- R7: After reset the queue is empty: `st_ready`=1, `fence_ready`=1, `mem_req_valid`=0 and `ld_rsp_valid`=0.
- R8: Two buffers on a shared memory whose writes take about 100 cycles run the store-then-load pattern. One core stores X=1 and then loads Y; the other stores Y=1 and then loads X. Without fences, both loads can return 0. With a fence between each store and its load, both loads return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| ld_valid | input | 1 | Core offers a load |
| ld_addr | input | AW | Load address |
| ld_ready | output | 1 | Load accepted this cycle when high with ld_valid |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_rsp_data | output | DW | Load result data |
| fence_valid | input | 1 | Core holds a fence |
| fence_ready | output | 1 | Queue empty; fence complete |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write (drain), 0 = read (load) |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Write data |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |

## Verification
The assertions check on every cycle that the queue never pops when empty, that its occupancy follows pushes and pops, that the oldest entry stays fixed until it drains, that a forwarded load answers one cycle later, that no memory read is issued for a load that hits, and that an empty queue drives no write. The directed scenarios show what needs a chain of events: which of several same-address stores gets forwarded, the write order that memory sees, a load passing an older store, the port going to a load while a write waits, and the two-core litmus outcome with and without fences.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
   // Source of the response currently being returned to the core.
   typedef enum logic {
      SRC_FWD = 1'b0,
      SRC_MEM = 1'b1
   } ld_src_e;
endpackage

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [AW-1:0]             push_addr,
   input  logic [DW-1:0]             push_data,
   input  logic                      pop,
   output logic                      full,
   output logic                      empty,
   output logic [AW-1:0]             head_addr,
   output logic [DW-1:0]             head_data,
   output logic [DEPTH-1:0][AW-1:0]  ent_addr,
   output logic [DEPTH-1:0][DW-1:0]  ent_data,
   output logic [PTR_W-1:0]          rd_ptr,
   output logic [CNT_W-1:0]          cnt
);
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;
   logic [PTR_W-1:0]         wr_ptr;

   initial begin : param_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "tsb_fifo: DEPTH must be a power of two >= 2");
      assert (AW > 0 && DW > 0)
         else $fatal(1, "tsb_fifo: widths must be positive");
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign full      = (cnt == CNT_W'(DEPTH));
   assign empty     = (cnt == '0);
   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];
   assign ent_addr  = addr_q;
   assign ent_data  = data_q;

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt != '0);

   // R1
   occ_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |=> cnt == $past(cnt) + 1'b1);

   // R1
   occ_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !push |=> cnt == $past(cnt) - 1'b1);

   // R2
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop && !empty |=> $stable(head_addr) && $stable(head_data));
endmodule

// File: rtl/tsb_fwd.sv
module tsb_fwd #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0][AW-1:0] ent_addr,
   input  logic [DEPTH-1:0][DW-1:0] ent_data,
   input  logic [PTR_W-1:0]         rd_ptr,
   input  logic [CNT_W-1:0]         cnt,
   input  logic [AW-1:0]            ld_addr,
   output logic                     hit,
   output logic [DW-1:0]            hit_data
);
   logic [DEPTH-1:0] match;

   // One comparator per slot; a slot counts only while it is occupied.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PTR_W-1:0] age;
      assign age      = PTR_W'(i) - rd_ptr;
      assign match[i] = (CNT_W'(age) < cnt) && (ent_addr[i] == ld_addr);
   end

   // Walk from oldest to newest; the last hit seen is the youngest.
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         logic [PTR_W-1:0] idx;
         idx = rd_ptr + PTR_W'(k);
         if (match[idx]) begin
            hit      = 1'b1;
            hit_data = ent_data[idx];
         end
      end
   end
endmodule

// File: rtl/tsb_port_arb.sv
module tsb_port_arb #(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          ld_req,
   input  logic [AW-1:0] ld_addr,
   input  logic          drain_req,
   input  logic [AW-1:0] head_addr,
   input  logic [DW-1:0] head_data,
   input  logic          mem_req_ready,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   output logic          ld_grant,
   output logic          pop
);
   // Loads own the port whenever they want it; drains fill idle cycles.
   always_comb begin
      mem_req_valid = ld_req || drain_req;
      mem_req_write = !ld_req;
      mem_req_addr  = ld_req ? ld_addr : head_addr;
      mem_req_wdata = head_data;
      ld_grant      = ld_req && mem_req_ready;
      pop           = !ld_req && drain_req && mem_req_ready;
   end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   output logic          st_ready,
   input  logic          ld_valid,
   input  logic [AW-1:0] ld_addr,
   output logic          ld_ready,
   output logic          ld_rsp_valid,
   output logic [DW-1:0] ld_rsp_data,
   input  logic          fence_valid,
   output logic          fence_ready,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data
);
   import tsb_pkg::*;

   logic                     push, pop, full, empty;
   logic [AW-1:0]            head_addr;
   logic [DW-1:0]            head_data;
   logic [DEPTH-1:0][AW-1:0] ent_addr;
   logic [DEPTH-1:0][DW-1:0] ent_data;
   logic [PTR_W-1:0]         rd_ptr;
   logic [CNT_W-1:0]         cnt;
   logic                     fwd_hit;
   logic [DW-1:0]            fwd_data;
   logic                     ld_busy, ld_grant, ld_open, take_fwd, ld_req;
   logic                     fwd_rsp_q;
   logic [DW-1:0]            fwd_data_q;
   ld_src_e                  rsp_src;

   assign push = st_valid && st_ready;

   tsb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_addr(st_addr), .push_data(st_data),
      .pop(pop), .full(full), .empty(empty),
      .head_addr(head_addr), .head_data(head_data),
      .ent_addr(ent_addr), .ent_data(ent_data),
      .rd_ptr(rd_ptr), .cnt(cnt)
   );

   tsb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
      .ent_addr(ent_addr), .ent_data(ent_data),
      .rd_ptr(rd_ptr), .cnt(cnt), .ld_addr(ld_addr),
      .hit(fwd_hit), .hit_data(fwd_data)
   );

   // A held fence with stores still queued shuts the load path.
   assign ld_open  = ld_valid && !ld_busy && !(fence_valid && !empty);
   assign take_fwd = ld_open && fwd_hit;
   assign ld_req   = ld_open && !fwd_hit;

   tsb_port_arb #(.AW(AW), .DW(DW)) u_arb (
      .ld_req(ld_req), .ld_addr(ld_addr),
      .drain_req(!empty), .head_addr(head_addr), .head_data(head_data),
      .mem_req_ready(mem_req_ready),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .ld_grant(ld_grant), .pop(pop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_busy    <= 1'b0;
         fwd_rsp_q  <= 1'b0;
         fwd_data_q <= '0;
      end else begin
         if (ld_grant)                    ld_busy <= 1'b1;
         else if (ld_busy && mem_rsp_valid) ld_busy <= 1'b0;
         fwd_rsp_q <= take_fwd;
         if (take_fwd) fwd_data_q <= fwd_data;
      end
   end

   assign rsp_src      = fwd_rsp_q ? SRC_FWD : SRC_MEM;
   assign st_ready     = !full;
   assign fence_ready  = empty;
   assign ld_ready     = take_fwd || ld_grant;
   assign ld_rsp_valid = fwd_rsp_q || (ld_busy && mem_rsp_valid);
   assign ld_rsp_data  = (rsp_src == SRC_FWD) ? fwd_data_q : mem_rsp_data;

   // R3
   fwd_rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && ld_ready && fwd_hit |=> ld_rsp_valid);

   // R4
   read_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_write |-> !fwd_hit);

   // R6
   empty_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ready |-> !(mem_req_valid && mem_req_write));

   // R6
   fence_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fence_valid && !fence_ready |-> !ld_ready);
endmodule

// File: tb/tso_store_buffer_tb.sv
module tso_store_buffer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WR_LAT     = 100;
   localparam int AW = 16, DW = 32, DEPTH = 8, NC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          st_valid [NC], st_ready [NC];
   logic [AW-1:0] st_addr  [NC];
   logic [DW-1:0] st_data  [NC];
   logic          ld_valid [NC], ld_ready [NC], ld_rsp_valid [NC];
   logic [AW-1:0] ld_addr  [NC];
   logic [DW-1:0] ld_rsp_data [NC];
   logic          fence_valid [NC], fence_ready [NC];
   logic          mq_valid [NC], mq_write [NC], mq_ready [NC], mr_valid [NC];
   logic [AW-1:0] mq_addr  [NC];
   logic [DW-1:0] mq_wdata [NC], mr_data [NC];

   for (genvar c = 0; c < NC; c++) begin : g_core
      tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
         .clk(clk), .rst_n(rst_n),
         .st_valid(st_valid[c]), .st_addr(st_addr[c]), .st_data(st_data[c]),
         .st_ready(st_ready[c]),
         .ld_valid(ld_valid[c]), .ld_addr(ld_addr[c]), .ld_ready(ld_ready[c]),
         .ld_rsp_valid(ld_rsp_valid[c]), .ld_rsp_data(ld_rsp_data[c]),
         .fence_valid(fence_valid[c]), .fence_ready(fence_ready[c]),
         .mem_req_valid(mq_valid[c]), .mem_req_write(mq_write[c]),
         .mem_req_addr(mq_addr[c]), .mem_req_wdata(mq_wdata[c]),
         .mem_req_ready(mq_ready[c]),
         .mem_rsp_valid(mr_valid[c]), .mem_rsp_data(mr_data[c])
      );
   end

   // Shared memory: reads answer next cycle, writes need WR_LAT cycles.
   logic [DW-1:0] mem [16];
   int            wcnt [NC];
   logic          pre_we, pre_clr;
   logic [3:0]    pre_addr;
   logic [DW-1:0] pre_data;
   logic [AW-1:0] wlog [32];
   int            wlog_n;

   always_comb
      for (int p = 0; p < NC; p++)
         mq_ready[p] = !mq_write[p] || (wcnt[p] >= WR_LAT - 1);

   always @(posedge clk) begin
      if (pre_clr) for (int i = 0; i < 16; i++) mem[i] <= '0;
      if (pre_we)  mem[pre_addr] <= pre_data;
      for (int p = 0; p < NC; p++) begin
         if (!rst_n) begin
            wcnt[p]     <= 0;
            mr_valid[p] <= 1'b0;
         end else begin
            mr_valid[p] <= mq_valid[p] && !mq_write[p];
            mr_data[p]  <= mem[mq_addr[p][3:0]];
            if (mq_valid[p] && mq_write[p]) begin
               if (mq_ready[p]) begin
                  mem[mq_addr[p][3:0]] <= mq_wdata[p];
                  wcnt[p] <= 0;
                  if (p == 0 && wlog_n < 32) begin
                     wlog[wlog_n] <= mq_addr[p];
                     wlog_n <= wlog_n + 1;
                  end
               end else begin
                  wcnt[p] <= wcnt[p] + 1;
               end
            end
         end
      end
   end

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_store(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      st_valid[c] = 1'b1; st_addr[c] = a; st_data[c] = d;
      #1;
      while (!st_ready[c]) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      st_valid[c] = 1'b0;
   endtask

   task automatic do_load(input int c, input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output int lat);
      @(negedge clk);
      ld_valid[c] = 1'b1; ld_addr[c] = a;
      #1;
      lat = 0;
      while (!ld_ready[c]) begin @(negedge clk); #1; lat++; end
      @(posedge clk); #1;
      ld_valid[c] = 1'b0;
      @(negedge clk);
      lat++;
      while (!ld_rsp_valid[c]) begin @(negedge clk); lat++; end
      d = ld_rsp_data[c];
   endtask

   task automatic do_fence(input int c);
      @(negedge clk);
      fence_valid[c] = 1'b1;
      #1;
      while (!fence_ready[c]) begin @(negedge clk); #1; end
      @(negedge clk);
      fence_valid[c] = 1'b0;
   endtask

   task automatic mem_clear();
      @(negedge clk); pre_clr = 1'b1;
      @(negedge clk); pre_clr = 1'b0;
   endtask

   task automatic mem_put(input logic [3:0] a, input logic [DW-1:0] d);
      @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = d;
      @(negedge clk); pre_we = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(st_ready[0] == 1'b1, "R7 st_ready", 32'(st_ready[0]), 1);
      chk(fence_ready[0] == 1'b1, "R7 fence_ready", 32'(fence_ready[0]), 1);
      chk(mq_valid[0] == 1'b0, "R7 mem_req_valid", 32'(mq_valid[0]), 0);
      chk(ld_rsp_valid[0] == 1'b0, "R7 ld_rsp_valid", 32'(ld_rsp_valid[0]), 0);
   endtask

   task automatic t_forward();
      logic [DW-1:0] d; int lat;
      mem_put(4'h5, 32'h0000_0abc);
      do_store(0, 16'h5, 32'h11);
      do_store(0, 16'h5, 32'h22);
      do_store(0, 16'h5, 32'h33);
      #1;
      chk(fence_ready[0] == 1'b0, "R6 fence_ready low with queue", 32'(fence_ready[0]), 0);
      do_load(0, 16'h5, d, lat);
      chk(d == 32'h33, "R3 youngest forward", d, 32'h33);
      chk(lat == 1, "R3 forward latency", 32'(lat), 1);
      chk(mem[5] == 32'h0abc, "R3 memory still stale", mem[5], 32'h0abc);
      do_fence(0);
      chk(mem[5] == 32'h33, "R2 final drained value", mem[5], 32'h33);
   endtask

   task automatic t_bypass();
      logic [DW-1:0] d; int lat;
      mem_put(4'h9, 32'h77);
      do_store(0, 16'h3, 32'h55);
      do_load(0, 16'h9, d, lat);
      chk(d == 32'h77, "R4 bypass data", d, 32'h77);
      chk(mem[3] == 32'h0, "R4 older store not yet in memory", mem[3], 0);
      do_fence(0);
   endtask

   task automatic t_priority();
      logic [DW-1:0] d; int lat;
      do_store(0, 16'h6, 32'h66);
      repeat (5) @(negedge clk);
      chk(mq_valid[0] && mq_write[0], "R5 drain waiting", 32'(mq_write[0]), 1);
      @(negedge clk);
      ld_valid[0] = 1'b1; ld_addr[0] = 16'hA;
      #1;
      chk(mq_valid[0] && !mq_write[0], "R5 port carries load", 32'(mq_write[0]), 0);
      ld_valid[0] = 1'b0;
      do_load(0, 16'hA, d, lat);
      chk(lat == 1, "R5 load not delayed by write", 32'(lat), 1);
      do_fence(0);
   endtask

   task automatic t_order();
      wlog_n = 0;
      do_store(0, 16'h3, 32'hA3);
      do_store(0, 16'h7, 32'hA7);
      do_store(0, 16'h1, 32'hA1);
      do_fence(0);
      chk(wlog_n == 3, "R2 write count", 32'(wlog_n), 3);
      chk(wlog[0] == 16'h3, "R2 first write", 32'(wlog[0]), 3);
      chk(wlog[1] == 16'h7, "R2 second write", 32'(wlog[1]), 7);
      chk(wlog[2] == 16'h1, "R2 third write", 32'(wlog[2]), 1);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH - 1; i++) do_store(0, AW'(i), DW'(i));
      #1;
      chk(st_ready[0] == 1'b1, "R1 ready at DEPTH-1", 32'(st_ready[0]), 1);
      do_store(0, 16'hF, 32'hF);
      #1;
      chk(st_ready[0] == 1'b0, "R1 stall when full", 32'(st_ready[0]), 0);
      do_fence(0);
      #1;
      chk(st_ready[0] == 1'b1, "R1 ready after drain", 32'(st_ready[0]), 1);
   endtask

   task automatic t_fence_block();
      logic [DW-1:0] d; int lat;
      do_store(0, 16'h2, 32'h2);
      @(negedge clk);
      fence_valid[0] = 1'b1; ld_valid[0] = 1'b1; ld_addr[0] = 16'h4;
      #1;
      chk(ld_ready[0] == 1'b0, "R6 load blocked by fence", 32'(ld_ready[0]), 0);
      ld_valid[0] = 1'b0;
      while (!fence_ready[0]) begin @(negedge clk); #1; end
      @(negedge clk); fence_valid[0] = 1'b0;
      do_load(0, 16'h2, d, lat);
      chk(d == 32'h2, "R6 load after fence sees memory", d, 32'h2);
   endtask

   task automatic t_litmus(input bit fenced);
      logic [DW-1:0] r0, r1;
      mem_clear();
      fork
         begin
            int l;
            do_store(0, 16'h1, 32'h1);
            if (fenced) do_fence(0);
            do_load(0, 16'h2, r0, l);
         end
         begin
            int l;
            do_store(1, 16'h2, 32'h1);
            if (fenced) do_fence(1);
            do_load(1, 16'h1, r1, l);
         end
      join
      if (!fenced) begin
         chk(r0 == 0 && r1 == 0, "R8 both loads zero without fence", {r0[15:0], r1[15:0]}, 0);
      end else begin
         chk(r0 == 1 && r1 == 1, "R8 fenced loads see stores", {r0[15:0], r1[15:0]}, 32'h0001_0001);
         chk(!(r0 == 0 && r1 == 0), "R8 no zero-zero with fence", {r0[15:0], r1[15:0]}, 32'h0001_0001);
      end
      fork do_fence(0); do_fence(1); join
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin
         st_valid[c] = 0; st_addr[c] = 0; st_data[c] = 0;
         ld_valid[c] = 0; ld_addr[c] = 0; fence_valid[c] = 0;
      end
      pre_we = 0; pre_clr = 1; pre_addr = 0; pre_data = 0; wlog_n = 0;
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1; pre_clr = 0;
      t_reset();
      t_forward();
      t_bypass();
      t_priority();
      t_order();
      t_full();
      t_fence_block();
      t_litmus(1'b0);
      t_litmus(1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule